// File: doc/BRIEF.md
# Error Counter Snapshot Bank

This block keeps one free-running event counter for each pairing of framer channel and error kind, for example bit errors and framing errors. Every counter adds one for each single-cycle event pulse on its own input bit. When an update request arrives, all counters in the bank are copied in the same clock cycle into holding registers that the host can read. Each counter then starts a new interval from zero.

An update request can come from two sources. The first is an external pin, which is asynchronous to the clock and only counts while its enable bit is set. The second is a software bit. The two sources are combined into one request line, and only a low-to-high change on that line takes a snapshot. The line has to return low before another snapshot can happen. The host reads a held value through a plain combinational read port that is indexed by counter number.

Top module: `errsnap_top`

## Requirements
- R1: After reset, every holding register reads zero on `rd_data`.
- R2: A rising edge on `sw_upd` (driven synchronously) loads all holding registers at the next clock edge. Each register receives the number of events counted since the previous snapshot or since reset.
- R3: When `pin_upd_en` is 1, a rising edge on `upd_pin_async` loads the holding registers at the third clock edge after the pin changes. That is well inside 100 ns at the nominal clock. The value read after the first and second edges is still the old one.
- R4: When `pin_upd_en` is 0, the external pin has no effect and the holding registers keep their values.
- R5: The request line is the OR of (pin AND enable) with `sw_upd`. A request held high produces exactly one snapshot, and the line must go low before the next one.
- R6: While `sw_upd` is held high, a rising edge on the pin does not take another snapshot, because the combined request line is already high.
- R7: One snapshot captures every counter of every channel in the same cycle.
- R8: At a snapshot each counter restarts from zero. An event pulse in the snapshot cycle is counted in the new interval and not in the held value.
- R9: A counter stops at 2^CW-1 and does not wrap.
- R10: Counter number k = channel*NCTR + kind counts pulses on `err_evt[k]`. Its held value appears on `rd_data` while `rd_addr` = k. An address past the last counter reads zero.
- R11: Between snapshots the holding registers do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| upd_pin_async | input | 1 | External update strobe, asynchronous to clk |
| pin_upd_en | input | 1 | Lets the external strobe request updates |
| sw_upd | input | 1 | Software update bit, synchronous level |
| err_evt | input | NCH*NCTR | One-cycle event pulses, one bit per counter |
| rd_addr | input | AW | Counter index for the host read |
| rd_data | output | CW | Held value of the addressed counter |

## Verification
The assertions assume that `sw_upd`, `pin_upd_en` and `err_evt` are synchronous to `clk`. They also assume that an event is a single bit per counter per cycle, with no other meaning. Only the external strobe may change at any time. The bench drives every input on the falling edge, so the synchronizer always sees clean levels. The random phases keep pulses on the strobe and the software bit several cycles long, so that both the held-high and the re-armed cases come up. The counter width is reduced in the bench so that saturation is reached within a short run.

// File: rtl/errsnap_pkg.sv
package errsnap_pkg;
  // number of error kinds counted per channel (bit error, framing error)
  localparam int unsigned ERR_KINDS  = 2;
  // depth of the synchronizer on the external strobe
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/errsnap_sync.sv
module errsnap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/errsnap_req.sv
module errsnap_req (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync,
  input  logic pin_en,
  input  logic sw_upd,
  output logic snap
);
  logic req_d;
  logic req_q;

  always_comb begin
    req_d = (pin_sync & pin_en) | sw_upd;
    snap  = req_d & ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  // R5: a held request yields a single snapshot pulse
  a_r5_single_snap: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> !snap);
  // R6: sw held high masks any further request
  a_r6_sw_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_upd && $past(sw_upd)) |-> !snap);
endmodule

// File: rtl/errsnap_ctr.sv
module errsnap_ctr #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          snap,
  output logic [CW-1:0] hold
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] hold_q, hold_d;
  logic          hold_en;

  always_comb begin
    hold_en = snap;
    hold_d  = cnt_q;
    if (snap)                       cnt_d = {{(CW-1){1'b0}}, evt};
    else if (evt && cnt_q != MAXV)  cnt_d = cnt_q + 1'b1;
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign hold = hold_q;

  // R9: saturated counter never wraps
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !snap) |=> cnt_q == MAXV);
  // R8: after a snapshot the new interval holds at most the coincident event
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> cnt_q <= 1);
  // R11: holding register only moves on a snapshot
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(hold_q));
endmodule

// File: rtl/errsnap_top.sv
module errsnap_top #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned NCTR = errsnap_pkg::ERR_KINDS,
  parameter int unsigned CW   = 16,
  localparam int unsigned NTOT = NCH * NCTR,
  localparam int unsigned AW   = (NTOT > 1) ? $clog2(NTOT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_pin_async,
  input  logic            pin_upd_en,
  input  logic            sw_upd,
  input  logic [NTOT-1:0] err_evt,
  input  logic [AW-1:0]   rd_addr,
  output logic [CW-1:0]   rd_data
);
  logic              pin_sync;
  logic              snap;
  logic [CW-1:0]     hold_arr [NTOT];
  logic [NTOT*CW-1:0] hold_flat;

  errsnap_sync #(.STAGES(errsnap_pkg::SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(upd_pin_async), .sync_out(pin_sync));

  errsnap_req u_req (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .pin_en(pin_upd_en),
    .sw_upd(sw_upd), .snap(snap));

  for (genvar k = 0; k < NTOT; k++) begin : g_ctr
    errsnap_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .evt(err_evt[k]), .snap(snap),
      .hold(hold_arr[k]));
    assign hold_flat[k*CW +: CW] = hold_arr[k];
  end

  always_comb begin
    rd_data = '0;
    if (32'(rd_addr) < NTOT) rd_data = hold_arr[rd_addr];
  end

  // R4: with the pin gated off and no software request, nothing is captured
  a_r4_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_upd_en && !sw_upd) |=> $stable(hold_flat));
  // R7: all counters share one snapshot strobe
  a_r7_joint_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(hold_flat));
endmodule

// File: tb/errsnap_top_bench.sv
`timescale 1ns/1ps
module errsnap_top_bench;
  localparam int NCH = 4, NCTR = 2, CW = 4, NT = NCH*NCTR, AW = 3;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic upd_pin_async, pin_upd_en, sw_upd;
  logic [NT-1:0] err_evt;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] rd_data;

  always #2 clk = ~clk;

  errsnap_top #(.NCH(NCH), .NCTR(NCTR), .CW(CW)) u_errsnap_top (
    .clk(clk), .rst_n(rst_n), .upd_pin_async(upd_pin_async),
    .pin_upd_en(pin_upd_en), .sw_upd(sw_upd), .err_evt(err_evt),
    .rd_addr(rd_addr), .rd_data(rd_data));

  int checks = 0, fails = 0;
  int m_cnt [NT];
  int m_hold[NT];
  bit m_s1, m_s2, m_rq;
  bit cur_pin, cur_sw;

  function automatic int sat_inc(int v);
    return (v == MAXV) ? v : v + 1;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: drive after a negedge, model the next posedge, wait to next negedge
  task automatic cycle(logic [NT-1:0] e, bit pin, bit sw);
    bit req, snap;
    err_evt = e; upd_pin_async = pin; sw_upd = sw;
    cur_pin = pin; cur_sw = sw;
    req  = (m_s2 && pin_upd_en) || sw;
    snap = req && !m_rq;
    for (int k = 0; k < NT; k++) begin
      if (snap) begin m_hold[k] = m_cnt[k]; m_cnt[k] = e[k] ? 1 : 0; end
      else if (e[k]) m_cnt[k] = sat_inc(m_cnt[k]);
    end
    m_rq = req; m_s2 = m_s1; m_s1 = pin;
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < NT; a++) begin
      rd_addr = AW'(a);
      cycle('0, cur_pin, cur_sw);
      check(tag, int'(rd_data), m_hold[a]);
    end
  endtask

  task automatic sw_pulse();
    cycle('0, cur_pin, 1'b1);
    cycle('0, cur_pin, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed, hold5;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; upd_pin_async = 0; pin_upd_en = 0; sw_upd = 0;
    err_evt = '0; rd_addr = '0;
    for (int k = 0; k < NT; k++) begin m_cnt[k] = 0; m_hold[k] = 0; end
    m_s1 = 0; m_s2 = 0; m_rq = 0; cur_pin = 0; cur_sw = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < NT; a++) begin
      rd_addr = AW'(a); #0.5; check("R1", int'(rd_data), 0);
    end

    // R2 / R7: distinct counts on every counter, one software edge captures all
    for (int j = 0; j < NT; j++) cycle(NT'((1 << (j + 1)) - 1), 0, 0);
    sw_pulse();
    check_all("R2_R7");

    // R10: events only on counter 5
    sw_pulse();
    for (int j = 0; j < 3; j++) cycle(NT'(1 << 5), 0, 0);
    sw_pulse();
    for (int a = 0; a < NT; a++) begin
      rd_addr = AW'(a); cycle('0, 0, 0);
      check("R10", int'(rd_data), (a == 5) ? 3 : 0);
    end

    // R8: event coinciding with the snapshot goes into the new interval
    for (int j = 0; j < 2; j++) cycle('1, 0, 0);
    cycle('1, 0, 1);
    cycle('0, 0, 0);
    sw_pulse();
    rd_addr = 0; cycle('0, 0, 0);
    check("R8", int'(rd_data), 1);

    // R5: held software level yields one snapshot only
    cycle('0, 0, 1);
    for (int j = 0; j < 6; j++) cycle('1, 0, 1);
    rd_addr = 2; cycle('0, 0, 1);
    check("R5", int'(rd_data), 0);
    cycle('0, 0, 0);
    rd_addr = 2; cycle('0, 0, 0);
    check("R5", int'(rd_data), 0);
    sw_pulse();
    rd_addr = 2; cycle('0, 0, 0);
    check("R5", int'(rd_data), 6);

    // R4: pin disabled is ignored
    pin_upd_en = 0;
    for (int j = 0; j < 4; j++) cycle('1, 0, 0);
    for (int j = 0; j < 5; j++) cycle('0, 1, 0);
    cycle('0, 0, 0);
    check_all("R4");
    rd_addr = 2; cycle('0, 0, 0);
    check("R4", int'(rd_data), 6);

    // R3: enabled pin edge captures at the third edge
    pin_upd_en = 1;
    sw_pulse();
    for (int j = 0; j < 5; j++) cycle(NT'(1), 0, 0);
    rd_addr = 0;
    cycle('0, 1, 0); check("R3", int'(rd_data), 4);
    cycle('0, 1, 0); check("R3", int'(rd_data), 4);
    cycle('0, 1, 0); check("R3", int'(rd_data), 5);
    for (int j = 0; j < 3; j++) cycle('0, 0, 0);

    // R6: software held high masks the pin edge
    sw_pulse();
    cycle('0, 0, 1);
    for (int j = 0; j < 3; j++) cycle(NT'(2), 0, 1);
    for (int j = 0; j < 5; j++) cycle('0, 1, 1);
    rd_addr = 1; cycle('0, 1, 1);
    check("R6", int'(rd_data), 0);
    cycle('0, 0, 0); cycle('0, 0, 0); cycle('0, 0, 0);
    sw_pulse();
    rd_addr = 1; cycle('0, 0, 0);
    check("R6", int'(rd_data), 3);

    // R9: saturation
    for (int j = 0; j < 40; j++) cycle(NT'(1 << 3), 0, 0);
    sw_pulse();
    rd_addr = 3; cycle('0, 0, 0);
    check("R9", int'(rd_data), MAXV);

    // random mix, checked against the model (R11 between snapshots)
    hold5 = 0;
    for (int r = 0; r < 40; r++) begin
      bit p, s;
      int plen;
      p = cur_pin; s = cur_sw;
      pin_upd_en = ($urandom % 4) != 0;
      for (int j = 0; j < 60; j++) begin
        if (($urandom % 8) == 0) p = ~p;
        if (($urandom % 10) == 0) s = ~s;
        plen = $urandom % 3;
        cycle(NT'($urandom) & NT'($urandom >> plen), p, s);
      end
      check_all("R11");
      hold5 = hold5 + 1;
    end
    finish_run();
  end
endmodule